// File: doc/BRIEF.md
# Embedded Sync Code Decoder for 8-bit 4:2:2 Video

This block watches a byte-wide multiplexed component video stream and picks out the four-byte timing reference codes embedded in it. A code is an all-ones byte, then two all-zeros bytes, then a status byte. The status byte carries the field bit F, the vertical blanking bit V, the start/end bit H and four protection bits. The decoder checks the protection bits. It keeps the last valid F, V and H as field, vertical and horizontal sync levels, and it reports start-of-video and end-of-video codes as single-cycle pulses.

When a valid start code has V clear, the block opens an active window. Each following byte is passed out delayed by one register stage, together with an active strobe and a tag that names the byte's place in the chroma/luma interleave. The window closes as soon as the all-ones byte of the next code arrives. A status byte that fails the protection check raises an error pulse and changes no sync state.

Top module: `vid_ref_decoder`

## Requirements
- R1: After the bytes FFh, 00h, 00h, a status byte with bit 7 set and correct protection bits raises `sav_pulse` (H = bit 4 = 0) or `eav_pulse` (H = 1) for exactly one cycle, in the cycle after the status byte is taken in.
- R2: The protection bits are bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H, where F = bit 6, V = bit 5 and H = bit 4. A status byte that follows the three preamble bytes but has a protection mismatch or bit 7 clear raises `code_err` for one cycle and no start or end pulse.
- R3: A status byte that fails the check leaves `hsync`, `vsync` and `field` unchanged.
- R4: `hsync`, `vsync` and `field` equal the H, V and F bits of the most recent valid code, from the cycle after that code.
- R5: A valid code whose F differs from the current `field` raises `field_start` for one cycle.
- R6: After a valid start code with V = 0, `active` is high with the first following byte on `sample_data`, and it stays high until the all-ones byte of the next code arrives. In the cycle after that byte, `active` is low.
- R7: A start code with V = 1 opens no active window. Blanking filler bytes (80h, 10h) outside a window keep `active` low.
- R8: Inside a window, `sample_data` is the input byte delayed by one cycle. `sample_tag` counts 0 (Cb), 1 (Y), 2 (Cr), 3 (Y) and wraps. The count restarts at 0 with every start code, whatever phase the previous line ended in.
- R9: Under reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Multiplexed video byte |
| sample_data | output | 8 | Byte delayed by one cycle |
| sample_tag | output | 2 | Interleave position of `sample_data` (0 Cb, 1 Y, 2 Cr, 3 Y) |
| active | output | 1 | `sample_data` is an active-window sample |
| hsync | output | 1 | H bit of the last valid code |
| vsync | output | 1 | V bit of the last valid code |
| field | output | 1 | F bit of the last valid code |
| field_start | output | 1 | One-cycle pulse when F changes |
| sav_pulse | output | 1 | Valid start-of-video code seen |
| eav_pulse | output | 1 | Valid end-of-video code seen |
| code_err | output | 1 | Status byte failed the protection check |

## Verification
The assertions check on every cycle that:
- at most one of the start, end and error pulses is high;
- an error leaves the three sync levels untouched;
- the start and end pulses agree with the horizontal level;
- a field-start pulse only comes with a real change of `field`;
- the window only opens right after a start pulse, with the tag at 0;
- the tag steps by one from each active cycle to the next.

Only the bench's scenarios can show that the right status bytes are accepted and the wrong ones rejected. It does this by sweeping all 256 values of the byte after a preamble against parity computed in the bench. The scenarios also show that the window closes on the first all-ones byte, that the bytes carried through are correct, and that the tag restarts after a line that ended mid-group.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
  typedef enum logic [1:0] {
    TAG_CB = 2'd0,
    TAG_YA = 2'd1,
    TAG_CR = 2'd2,
    TAG_YB = 2'd3
  } smp_tag_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } sync_bits_t;
endpackage

// File: rtl/vrd_preamble.sv
module vrd_preamble #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic          hdr_seen
);
  localparam int HIST = 3;
  localparam logic [DW-1:0] ONES  = {DW{1'b1}};
  localparam logic [DW-1:0] ZEROS = {DW{1'b0}};

  logic [DW-1:0] hist [HIST];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) hist[i] <= ZEROS;
    end else begin
      hist[0] <= din;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end

  // oldest byte all ones, the two newer ones all zeros
  assign hdr_seen = (hist[2] == ONES) && (hist[1] == ZEROS) && (hist[0] == ZEROS);
endmodule

// File: rtl/vrd_xy_check.sv
module vrd_xy_check
  import vrd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  logic          hdr_seen,
  output logic          is_code,
  output logic          code_ok,
  output sync_bits_t    bits
);
  localparam int MSB = DW - 1;

  logic [3:0] prot_exp;

  always_comb begin
    bits.f   = din[MSB-1];
    bits.v   = din[MSB-2];
    bits.h   = din[MSB-3];
    prot_exp = {bits.v ^ bits.h, bits.f ^ bits.h, bits.f ^ bits.v, bits.f ^ bits.v ^ bits.h};
    is_code  = hdr_seen;
    code_ok  = hdr_seen && din[MSB] && (din[MSB-4 -: 4] == prot_exp);
  end
endmodule

// File: rtl/vrd_flags.sv
module vrd_flags
  import vrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       is_code,
  input  logic       code_ok,
  input  sync_bits_t bits,
  output logic       hsync,
  output logic       vsync,
  output logic       field,
  output logic       field_start,
  output logic       sav_pulse,
  output logic       eav_pulse,
  output logic       code_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      field       <= 1'b0;
      field_start <= 1'b0;
      sav_pulse   <= 1'b0;
      eav_pulse   <= 1'b0;
      code_err    <= 1'b0;
    end else begin
      sav_pulse   <= code_ok && !bits.h;
      eav_pulse   <= code_ok && bits.h;
      code_err    <= is_code && !code_ok;
      field_start <= code_ok && (bits.f != field);
      if (code_ok) begin
        hsync <= bits.h;
        vsync <= bits.v;
        field <= bits.f;
      end
    end
  end
endmodule

// File: rtl/vid_ref_decoder.sv
module vid_ref_decoder
  import vrd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sample_data,
  output logic [1:0]    sample_tag,
  output logic          active,
  output logic          hsync,
  output logic          vsync,
  output logic          field,
  output logic          field_start,
  output logic          sav_pulse,
  output logic          eav_pulse,
  output logic          code_err
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic       hdr_seen;
  logic       is_code;
  logic       code_ok;
  sync_bits_t bits;
  logic       line_open;
  smp_tag_e   phase;
  logic       opens;
  logic       carries;

  vrd_preamble #(.DW(DW)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .hdr_seen (hdr_seen)
  );

  vrd_xy_check #(.DW(DW)) u_xy (
    .din      (din),
    .hdr_seen (hdr_seen),
    .is_code  (is_code),
    .code_ok  (code_ok),
    .bits     (bits)
  );

  vrd_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .is_code     (is_code),
    .code_ok     (code_ok),
    .bits        (bits),
    .hsync       (hsync),
    .vsync       (vsync),
    .field       (field),
    .field_start (field_start),
    .sav_pulse   (sav_pulse),
    .eav_pulse   (eav_pulse),
    .code_err    (code_err)
  );

  assign opens   = code_ok && !bits.h && !bits.v;
  assign carries = line_open && (din != ONES);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_open   <= 1'b0;
      phase       <= TAG_CB;
      active      <= 1'b0;
      sample_tag  <= 2'd0;
      sample_data <= '0;
    end else begin
      sample_data <= din;
      active      <= carries;
      sample_tag  <= carries ? phase : 2'd0;
      if (opens)            line_open <= 1'b1;
      else if (din == ONES) line_open <= 1'b0;
      if (opens)        phase <= TAG_CB;
      else if (carries) phase <= smp_tag_e'(phase + 2'd1);
    end
  end
endmodule

// File: rtl/vrd_checker.sv
module vrd_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] sample_tag,
  input logic       active,
  input logic       hsync,
  input logic       vsync,
  input logic       field,
  input logic       field_start,
  input logic       sav_pulse,
  input logic       eav_pulse,
  input logic       code_err
);
  assert_one_event_R1: assert property (@(posedge clk) disable iff (rst)
    $countones({sav_pulse, eav_pulse, code_err}) <= 1);

  assert_err_no_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    code_err |-> !sav_pulse && !eav_pulse);

  assert_err_holds_state_R3: assert property (@(posedge clk) disable iff (rst)
    code_err |-> $stable(hsync) && $stable(vsync) && $stable(field));

  assert_sav_level_R4: assert property (@(posedge clk) disable iff (rst)
    sav_pulse |-> !hsync);

  assert_eav_level_R4b: assert property (@(posedge clk) disable iff (rst)
    eav_pulse |-> hsync);

  assert_field_change_R5: assert property (@(posedge clk) disable iff (rst)
    field_start |-> field != $past(field));

  assert_open_after_sav_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(sav_pulse) && !vsync);

  assert_first_tag_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> sample_tag == 2'd0);

  assert_tag_step_R8: assert property (@(posedge clk) disable iff (rst)
    active && $past(active) |-> sample_tag == $past(sample_tag) + 2'd1);
endmodule

bind vid_ref_decoder vrd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .sample_tag  (sample_tag),
  .active      (active),
  .hsync       (hsync),
  .vsync       (vsync),
  .field       (field),
  .field_start (field_start),
  .sav_pulse   (sav_pulse),
  .eav_pulse   (eav_pulse),
  .code_err    (code_err)
);

// File: tb/tb_vid_ref_decoder.sv
module tb_vid_ref_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] sample_data;
  logic [1:0] sample_tag;
  logic       active, hsync, vsync, field, field_start, sav_pulse, eav_pulse, code_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic mf = 1'b0, mv = 1'b0, mh = 1'b0;

  always #2 clk = ~clk;

  vid_ref_decoder dut (
    .clk(clk), .rst(rst), .din(din),
    .sample_data(sample_data), .sample_tag(sample_tag), .active(active),
    .hsync(hsync), .vsync(vsync), .field(field), .field_start(field_start),
    .sav_pulse(sav_pulse), .eav_pulse(eav_pulse), .code_err(code_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkxy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic send(input logic [7:0] b);
    din = b;
    @(posedge clk);
    #1;
  endtask

  task automatic preamble();
    send(8'hFF); send(8'h00); send(8'h00);
  endtask

  task automatic code(input logic f, input logic v, input logic h);
    preamble();
    send(mkxy(f, v, h));
    mf = f; mv = v; mh = h;
  endtask

  task automatic line(input int n, input logic f);
    code(f, 1'b0, 1'b0);
    chk("R6 closed on sav cycle", active, 0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = 8'(8'h20 + k * 7);
      send(b);
      chk("R6 active in window", active, 1);
      chk("R8 data delayed", sample_data, b);
      chk("R8 tag phase", sample_tag, k % 4);
    end
    send(8'hFF);
    chk("R6 closes on ff", active, 0);
    send(8'h00); send(8'h00); send(mkxy(f, 1'b0, 1'b1));
    mf = f; mv = 1'b0; mh = 1'b1;
    chk("R1 eav pulse", eav_pulse, 1);
    chk("R6 stays closed", active, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset outputs", {sample_data, sample_tag, active, hsync, vsync, field,
                             field_start, sav_pulse, eav_pulse, code_err}, 0);
    rst = 1'b0;

    // sweep every status byte after a preamble
    for (int x = 0; x < 256; x++) begin
      logic [7:0] xy = 8'(x);
      logic ok, pf, pv, ph, fs;
      pf = xy[6]; pv = xy[5]; ph = xy[4];
      ok = xy[7] && (xy[3:0] == {pv ^ ph, pf ^ ph, pf ^ pv, pf ^ pv ^ ph});
      fs = ok && (pf != mf);
      preamble();
      send(xy);
      chk("R2 err flag", code_err, !ok);
      chk("R1 sav", sav_pulse, ok && !ph);
      chk("R1 eav", eav_pulse, ok && ph);
      chk("R5 field start", field_start, fs);
      if (ok) begin mf = pf; mv = pv; mh = ph; end
      chk("R4 R3 sync levels", {hsync, vsync, field}, {mh, mv, mf});
      send(8'h80);
      chk("R1 pulse one cycle", {sav_pulse, eav_pulse, code_err, field_start}, 0);
    end

    // blanking filler before any window
    code(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      send(k[0] ? 8'h10 : 8'h80);
      chk("R7 filler inactive", active, 0);
    end

    line(6, 1'b0);
    line(16, 1'b0);
    code(1'b1, 1'b0, 1'b1);
    chk("R5 field start on change", field_start, 1);
    line(9, 1'b1);

    // vertical blanking start code opens nothing
    code(1'b1, 1'b1, 1'b0);
    chk("R4 vsync set", vsync, 1);
    for (int k = 0; k < 8; k++) begin
      send(8'h40 + 8'(k));
      chk("R7 no window in vblank", active, 0);
    end

    // corrupted code mid-stream holds state
    preamble();
    send(mkxy(1'b0, 1'b0, 1'b0) ^ 8'h01);
    chk("R2 corrupt flagged", code_err, 1);
    chk("R3 state held", {hsync, vsync, field}, {mh, mv, mf});
    send(8'h80);
    chk("R7 no window after error", active, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule